// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter of a 32-bit RISC core and decides, each cycle, where the next instruction comes from. A decoded control-transfer class, two register operand values, a 16-bit immediate and a 26-bit jump index arrive from decode. The block evaluates the branch condition, forms the target, and presents the next PC, a taken flag, the return address and the link-write request. The PC register loads the next PC on every clock edge.

Conditional branches come in two shapes. Equality and inequality compare two registers. The sign tests look at one register against zero. Branch offsets are word counts relative to the instruction after the branch. Jumps take their target either from the instruction's index field or from a full register value. Both jump kinds have a linking variant. The block also exposes a signed set-less-than result, in register and sign-extended-immediate forms. Software builds the missing relational branches from this result without risking the overflow that a subtraction would cause.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low the PC output is 0x0000_0000.
- R2: On every rising clock edge out of reset, pc_o takes the value that next_pc_o showed just before that edge.
- R3: Class 1 (equal) is taken when rs_val_i equals rt_val_i, and class 2 (not equal) is taken when they differ. With rt_val_i zero, class 2 acts as branch-if-nonzero.
- R4: Classes 3, 4, 5 and 6 test rs_val_i as a signed value: at least zero, at most zero, above zero and below zero, in that order. rt_val_i has no effect on them.
- R5: A taken branch sets next_pc_o to pc_o + 4 + (sign-extended imm_i shifted left by two). This holds at both offset extremes, imm_i = 0x7FFF (+32767 words) and imm_i = 0x8000 (-32768 words).
- R6: When a branch is not taken, or the class is 0, 11, 12 or an unused code (13 to 15), taken_o is 0 and next_pc_o is pc_o + 4.
- R7: Class 7 (direct jump) sets next_pc_o to {bits 31:28 of pc_o+4, jidx_i, 2'b00}. Class 8 (register jump) sets next_pc_o to rs_val_i. Both raise taken_o.
- R8: Class 9 (direct jump with link) behaves as class 7 and class 10 (register jump with link) behaves as class 8. Both raise link_we_o, with link_idx_o = 31 for class 9 and rd_idx_i for class 10. link_addr_o is always pc_o + 4, and link_we_o is 0 for every other class.
- R9: slt_o is 1 when rs_val_i is less than rt_val_i as signed 32-bit values and 0 otherwise. This includes operands of opposite sign and extreme magnitude.
- R10: slti_o is 1 when rs_val_i is less than the sign-extended imm_i as signed values and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Decoded control class (codes in R3 to R8) |
| rs_val_i | input | 32 | First register operand value |
| rt_val_i | input | 32 | Second register operand value |
| imm_i | input | 16 | Branch offset / compare immediate |
| jidx_i | input | 26 | Direct jump word index |
| rd_idx_i | input | 5 | Destination register for register-form link |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Program counter for the next cycle |
| taken_o | output | 1 | Control transfer taken |
| link_addr_o | output | 32 | Return address (pc_o + 4) |
| link_we_o | output | 1 | Write link address to a register |
| link_idx_o | output | 5 | Register receiving the link address |
| slt_o | output | 1 | Signed rs < rt |
| slti_o | output | 1 | Signed rs < sign-extended immediate |

## Verification
The only state is the PC register. A wrong value there shows at pc_o one edge after it is loaded. It also corrupts next_pc_o and link_addr_o combinationally in the same cycle, because both are derived from it. Faults in the compare or target logic show on next_pc_o and taken_o in the cycle the class is applied, before any edge. The bench therefore checks those outputs combinationally, and checks pc_o after each edge to catch a faulty register load within one cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    CT_SEQ    = 4'd0,
    CT_EQ     = 4'd1,
    CT_NE     = 4'd2,
    CT_GEZ    = 4'd3,
    CT_LEZ    = 4'd4,
    CT_GTZ    = 4'd5,
    CT_LTZ    = 4'd6,
    CT_JDIR   = 4'd7,
    CT_JREG   = 4'd8,
    CT_JLDIR  = 4'd9,
    CT_JLREG  = 4'd10,
    CT_SLT    = 4'd11,
    CT_SLTI   = 4'd12
  } ctl_op_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctl_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [XLEN-1:0]  imm_sx,
  output logic             cond_true,
  output logic             lt_ab,
  output logic             lt_aimm
);
  localparam int MSB = XLEN - 1;

  // Signed less-than without subtraction: opposite signs decide on the sign
  // of the left operand; equal signs reduce to an unsigned compare.
  function automatic logic signed_lt(input logic [XLEN-1:0] x,
                                     input logic [XLEN-1:0] y);
    if (x[MSB] != y[MSB]) return x[MSB];
    return (x < y);
  endfunction

  logic a_zero;
  logic a_neg;

  always_comb begin
    a_zero  = (a == '0);
    a_neg   = a[MSB];
    lt_ab   = signed_lt(a, b);
    lt_aimm = signed_lt(a, imm_sx);
    unique case (op)
      CT_EQ:   cond_true = (a == b);
      CT_NE:   cond_true = (a != b);
      CT_GEZ:  cond_true = !a_neg;
      CT_LEZ:  cond_true = a_neg || a_zero;
      CT_GTZ:  cond_true = !a_neg && !a_zero;
      CT_LTZ:  cond_true = a_neg;
      default: cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  input  logic [IDX_W-1:0] jidx,
  output logic [XLEN-1:0]  imm_sx,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  br_tgt,
  output logic [XLEN-1:0]  jd_tgt
);
  localparam int ALIGN  = 2;
  localparam int STEP   = 1 << ALIGN;
  localparam int HI_W   = XLEN - IDX_W - ALIGN;
  localparam int EXT_W  = XLEN - IMM_W;

  logic [XLEN-1:0] byte_off;

  always_comb begin
    imm_sx   = {{EXT_W{imm[IMM_W-1]}}, imm};
    byte_off = imm_sx << ALIGN;
    seq_pc   = pc + XLEN'(STEP);
    br_tgt   = seq_pc + byte_off;
    jd_tgt   = {seq_pc[XLEN-1 -: HI_W], jidx, {ALIGN{1'b0}}};
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int IDX_W    = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [IDX_W-1:0]  jidx_i,
  input  logic [RIDX_W-1:0] rd_idx_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   link_addr_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic              slt_o,
  output logic              slti_o
);
  localparam logic [XLEN-1:0]   RESET_PC = '0;
  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

  ctl_op_e         op;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic            pc_en;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jd_tgt;
  logic            cond_true;
  logic            lt_ab;
  logic            lt_aimm;

  assign op = ctl_op_e'(op_i);

  npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_target (
    .pc     (pc_q),
    .imm    (imm_i),
    .jidx   (jidx_i),
    .imm_sx (imm_sx),
    .seq_pc (seq_pc),
    .br_tgt (br_tgt),
    .jd_tgt (jd_tgt)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .op        (op),
    .a         (rs_val_i),
    .b         (rt_val_i),
    .imm_sx    (imm_sx),
    .cond_true (cond_true),
    .lt_ab     (lt_ab),
    .lt_aimm   (lt_aimm)
  );

  // Next-state selection
  always_comb begin
    pc_d       = seq_pc;
    taken_o    = 1'b0;
    link_we_o  = 1'b0;
    link_idx_o = LINK_IDX;
    unique case (op)
      CT_EQ, CT_NE, CT_GEZ, CT_LEZ, CT_GTZ, CT_LTZ: begin
        taken_o = cond_true;
        if (cond_true) pc_d = br_tgt;
      end
      CT_JDIR: begin
        taken_o = 1'b1;
        pc_d    = jd_tgt;
      end
      CT_JREG: begin
        taken_o = 1'b1;
        pc_d    = rs_val_i;
      end
      CT_JLDIR: begin
        taken_o   = 1'b1;
        pc_d      = jd_tgt;
        link_we_o = 1'b1;
      end
      CT_JLREG: begin
        taken_o    = 1'b1;
        pc_d       = rs_val_i;
        link_we_o  = 1'b1;
        link_idx_o = rd_idx_i;
      end
      default: ;
    endcase
  end

  assign pc_en = 1'b1;

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o        = pc_q;
  assign next_pc_o   = pc_d;
  assign link_addr_o = seq_pc;
  assign slt_o       = lt_ab;
  assign slti_o      = lt_aimm;

  // R2: the register follows the selected next PC
  a_r2_pc_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc_o == $past(next_pc_o));

  // R6: a non-taken cycle steps by one instruction
  a_r6_untaken_step: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> next_pc_o == pc_o + 32'd4);

  // R8: a link request only accompanies a taken jump
  a_r8_link_taken: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> taken_o);

  // R8: the return address is the sequential address
  a_r8_link_addr: assert property (@(posedge clk) disable iff (!rst_n)
    link_addr_o == pc_o + 32'd4);

  // R5: a taken branch target keeps word alignment relative to pc_o
  a_r5_target_align: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && op_i >= 4'd1 && op_i <= 4'd6) |-> next_pc_o[1:0] == pc_o[1:0]);

  // R9: slt is never set for equal operands
  a_r9_slt_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_val_i == rt_val_i) |-> !slt_o);
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [31:0] rs_val_i, rt_val_i;
  logic [15:0] imm_i;
  logic [25:0] jidx_i;
  logic [4:0]  rd_idx_i;
  logic [31:0] pc_o, next_pc_o, link_addr_o;
  logic        taken_o, link_we_o, slt_o, slti_o;
  logic [4:0]  link_idx_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .rs_val_i(rs_val_i),
    .rt_val_i(rt_val_i), .imm_i(imm_i), .jidx_i(jidx_i), .rd_idx_i(rd_idx_i),
    .pc_o(pc_o), .next_pc_o(next_pc_o), .taken_o(taken_o),
    .link_addr_o(link_addr_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
    .slt_o(slt_o), .slti_o(slti_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] rs, input logic [31:0] rt,
                       input logic [15:0] imm);
    op_i = op; rs_val_i = rs; rt_val_i = rt; imm_i = imm;
    #1;
  endtask

  task automatic step_and_check(input string req, input logic [31:0] exp_pc);
    @(posedge clk); #2;
    chk(req, pc_o, exp_pc);
    @(negedge clk);
  endtask

  function automatic logic [31:0] brt(input logic [31:0] pc, input logic [15:0] imm);
    return pc + 32'd4 + ({{16{imm[15]}}, imm} << 2);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    apply(4'd0, 0, 0, 0); jidx_i = '0; rd_idx_i = '0;
    #12;
    chk("R1 reset pc", pc_o, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    apply(4'd0, 0, 0, 0);
    chk("R6 seq next", next_pc_o, 32'h4);
    chk("R6 seq not taken", {31'b0, taken_o}, 0);
    step_and_check("R2 pc loads next", 32'h4);
  endtask

  task automatic t_eq_ne();
    logic [31:0] pc = pc_o;
    apply(4'd1, 32'h55, 32'h55, 16'h0010);
    chk("R3 beq equal taken", next_pc_o, brt(pc, 16'h0010));
    apply(4'd1, 32'h55, 32'h56, 16'h0010);
    chk("R3 beq differ not taken", next_pc_o, pc + 4);
    apply(4'd2, 32'h7, 32'h0, 16'h0003);
    chk("R3 bnez nonzero taken", {31'b0, taken_o}, 1);
    apply(4'd2, 32'h0, 32'h0, 16'h0003);
    chk("R3 bnez zero not taken", {31'b0, taken_o}, 0);
  endtask

  task automatic t_sign();
    logic [31:0] vals [3] = '{32'h0, 32'hFFFF_FFFF, 32'h0000_0001};
    for (int o = 3; o <= 6; o++) begin
      for (int i = 0; i < 3; i++) begin
        logic signed [31:0] v = vals[i];
        logic exp_t;
        case (o)
          3: exp_t = (v >= 0);
          4: exp_t = (v <= 0);
          5: exp_t = (v > 0);
          default: exp_t = (v < 0);
        endcase
        apply(4'(o), vals[i], 32'hDEAD_BEEF, 16'h0020);
        chk("R4 sign test taken", {31'b0, taken_o}, {31'b0, exp_t});
        apply(4'(o), vals[i], vals[i], 16'h0020);
        chk("R4 rt ignored", {31'b0, taken_o}, {31'b0, exp_t});
      end
    end
  endtask

  task automatic t_extremes();
    apply(4'd8, 32'h0004_0000, 0, 0);
    chk("R7 jreg target", next_pc_o, 32'h0004_0000);
    step_and_check("R7 jreg loads", 32'h0004_0000);
    apply(4'd1, 32'h5, 32'h5, 16'h8000);
    chk("R5 backward extreme", next_pc_o, 32'h0002_0004);
    step_and_check("R5 backward pc", 32'h0002_0004);
    apply(4'd2, 32'h1, 32'h0, 16'h7FFF);
    chk("R5 forward extreme", next_pc_o, 32'h0004_0004);
    step_and_check("R5 forward pc", 32'h0004_0004);
  endtask

  task automatic t_jumps();
    apply(4'd8, 32'hA000_0100, 0, 0);
    step_and_check("R7 jreg high", 32'hA000_0100);
    jidx_i = 26'h2AB_CDEF;
    apply(4'd7, 0, 0, 0);
    chk("R7 jdir target", next_pc_o, {4'hA, 26'h2AB_CDEF, 2'b00});
    chk("R8 jdir no link", {31'b0, link_we_o}, 0);
    apply(4'd9, 0, 0, 0);
    chk("R8 jal target", next_pc_o, {4'hA, 26'h2AB_CDEF, 2'b00});
    chk("R8 jal we", {31'b0, link_we_o}, 1);
    chk("R8 jal idx", {27'b0, link_idx_o}, 31);
    chk("R8 link addr", link_addr_o, 32'hA000_0104);
    rd_idx_i = 5'd9;
    apply(4'd10, 32'h0000_2000, 0, 0);
    chk("R8 jalr target", next_pc_o, 32'h0000_2000);
    chk("R8 jalr idx", {27'b0, link_idx_o}, 9);
    chk("R8 jalr we", {31'b0, link_we_o}, 1);
    apply(4'd14, 32'h0000_2000, 0, 0);
    chk("R6 unused code", next_pc_o, 32'hA000_0104);
    chk("R8 unused no link", {31'b0, link_we_o}, 0);
  endtask

  task automatic t_slt();
    apply(4'd11, 32'h7FFF_FFFF, 32'h8000_0000, 0);
    chk("R9 max vs min", {31'b0, slt_o}, 0);
    chk("R6 slt not taken", {31'b0, taken_o}, 0);
    apply(4'd11, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    chk("R9 min vs max", {31'b0, slt_o}, 1);
    apply(4'd11, 32'hFFFF_FFFF, 32'h0, 0);
    chk("R9 -1 vs 0", {31'b0, slt_o}, 1);
    apply(4'd11, 32'h1234, 32'h1234, 0);
    chk("R9 equal", {31'b0, slt_o}, 0);
    apply(4'd12, 32'hFFFF_FFFE, 0, 16'hFFFF);
    chk("R10 -2 vs -1", {31'b0, slti_o}, 1);
    apply(4'd12, 32'h0000_0005, 0, 16'h8000);
    chk("R10 5 vs -32768", {31'b0, slti_o}, 0);
    apply(4'd12, 32'h0000_FFFF, 0, 16'hFFFF);
    chk("R10 65535 vs -1", {31'b0, slti_o}, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_eq_ne();
        t_sign();
        t_extremes();
        t_jumps();
        t_slt();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule